// File: doc/BRIEF.md
# Pulse Period and Timestamp Meter

This block times a digital pulse train, for example a tachometer signal, against a free-running tick counter that runs on the block's own clock. The pulse input is first brought into the clock domain by a short synchronizer chain. Each rising edge found after that chain stores the current tick count as the edge timestamp. The same edge also produces the period, which is the distance in ticks back to the previous edge. The timestamp, the period, a period-valid flag and a one-cycle edge strobe are all held in registers, so any consumer in the same clock domain can sample them at any time.

Two ways of forming the period are available through a parameter. The subtract variant takes the difference between the tick count and the stored timestamp. The count variant keeps a run-length counter that restarts on each edge, so no wide subtractor is needed. Both variants give the same period values. A period too large for its output saturates at all-ones and does not wrap. Every register in the input path comes out of reset at logic 1. An input that is already high when reset is released is therefore not taken as an edge.

Top module: `pulse_period_meter`

## Requirements
- R1: The tick counter is 0 while reset is held and goes up by one on every clock after that. When `pulse_in` rises in a cycle where the counter holds N, the stored timestamp `stamp_q` becomes N+2 with the default two-stage synchronizer.
- R2: `edge_stb` and the output registers update on the third rising clock edge after `pulse_in` goes high. After the first and second of those clock edges, `edge_stb` is still 0.
- R3: A falling edge of `pulse_in` produces no strobe and leaves `stamp_q`, `period_q` and `period_ok` unchanged.
- R4: If `pulse_in` is high when reset is released and stays high, no edge is detected. The first strobe after reset comes only from a later low-to-high transition.
- R5: On each edge, `period_q` is set to the difference between the new timestamp and the previous one, taken in the low `PER_W` bits.
- R6: If that difference is 2^PER_W or more, `period_q` is set to all-ones. With the count variant, differences of 2^PER_W-1 and above also give all-ones.
- R7: `edge_stb` is high for exactly one cycle per rising edge. It is high in the cycle in which `stamp_q` and `period_q` show their new values, and both outputs hold their values in every other cycle.
- R8: `period_ok` is 0 after reset and still 0 after the first edge. It goes to 1 together with the strobe of the second edge and stays at 1 until the next reset.
- R9: While `rst_n` is low (synchronous, active low), `stamp_q`, `period_q`, `period_ok` and `edge_stb` are driven to 0.
- R10: The count variant (`MODE` = `PM_COUNT`) gives the same `period_q` values as the subtract variant (`MODE` = `PM_SUBTRACT`) for the same input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the tick counter advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse train being measured |
| edge_stb | output | 1 | One-cycle strobe marking fresh timestamp and period values |
| stamp_q | output | TS_W (64) | Tick count captured at the latest detected rising edge |
| period_q | output | PER_W (32) | Ticks between the last two edges, saturating |
| period_ok | output | 1 | High once two edges have been seen since reset |

## Verification
The hardest case to reach from the ports is saturation. At the default widths it needs more than four billion cycles between edges. The bench therefore adds two copies of the block with an 8-bit period, one for each variant, and drives all three from the same pulse line. Gaps of a few hundred cycles then cross the 8-bit limit, while the wide copy gives the true period as a cross-check. Startup suppression is the other case that is hard to create. It is reached by holding the input high through the whole reset and past its release, and then counting strobes.

// File: rtl/pm_pkg.sv
// Shared definitions for the pulse period meter.
// Assumes: nothing beyond IEEE 1800-2017.
package pm_pkg;

    // How the period is formed on each edge.
    typedef enum logic {
        PM_SUBTRACT = 1'b0,   // tick count minus stored timestamp
        PM_COUNT    = 1'b1    // run-length counter restarted at each edge
    } pm_mode_e;

endpackage

// File: rtl/pm_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
// Each stage resets to logic 1, so a high input at startup does not look
// like a rising edge. Assumes STAGES >= 2.
module pm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Move the input down the flop chain, one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pm_edge.sv
// Rising-edge detector for a signal already in the clock domain.
// The previous-sample register resets to 1, so no edge can be reported
// in the first cycle after reset. Output is combinational.
module pm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    logic prev_q;

    // Keep last cycle's sample of the signal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sig;
        end
    end

    // New sample is 1 and old sample is 0: the value has gone up.
    assign rise = sig & ~prev_q;

endmodule

// File: rtl/pm_ticker.sv
// Free-running tick counter, cleared by reset, +1 per clock.
// Assumes that wrap-around at TS_W bits is far enough away to ignore.
module pm_ticker #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] tick
);

    // Advance the time base by one tick each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

endmodule

// File: rtl/pm_period_unit.sv
// Stores timestamp and period on each edge and produces the strobe and
// the valid flag. MODE picks how the period is formed. Both variants
// saturate at all-ones. Assumes PER_W < TS_W.
module pm_period_unit
    import pm_pkg::*;
#(
    parameter int       TS_W  = 64,
    parameter int       PER_W = 32,
    parameter pm_mode_e MODE  = PM_SUBTRACT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [TS_W-1:0]  tick,
    output logic             strobe,
    output logic [TS_W-1:0]  stamp,
    output logic [PER_W-1:0] period,
    output logic             valid
);

    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    logic [PER_W-1:0] per_next;
    logic             seen_one_q;

    generate
        if (MODE == PM_SUBTRACT) begin : g_sub
            logic [TS_W-1:0] gap;
            logic            gap_over;

            // Distance from the stored timestamp; the old value is read
            // here and replaced only at the next clock edge.
            always_comb begin
                gap      = tick - stamp;
                gap_over = |gap[TS_W-1:PER_W];
                per_next = gap_over ? PER_MAX : gap[PER_W-1:0];
            end
        end else begin : g_cnt
            logic [PER_W-1:0] run_q;

            // Run length since the last edge; the edge cycle itself
            // counts as one, so the value matches the tick difference.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q <= '0;
                end else if (rise) begin
                    run_q <= {{(PER_W-1){1'b0}}, 1'b1};
                end else if (run_q != PER_MAX) begin
                    run_q <= run_q + 1'b1;
                end
            end

            assign per_next = run_q;
        end
    endgenerate

    // Store timestamp, period and flags when an edge is detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe     <= 1'b0;
            stamp      <= '0;
            period     <= '0;
            valid      <= 1'b0;
            seen_one_q <= 1'b0;
        end else begin
            strobe <= rise;
            if (rise) begin
                stamp      <= tick;
                period     <= per_next;
                seen_one_q <= 1'b1;
                valid      <= valid | seen_one_q;
            end
        end
    end

endmodule

// File: rtl/pulse_period_meter.sv
// Top level of the pulse period and timestamp meter: synchronizer, edge
// detector, tick counter and period unit. All outputs are registered.
// Assumes pulse_in is asynchronous and every consumer uses clk.
module pulse_period_meter
    import pm_pkg::*;
#(
    parameter int       TS_W        = 64,
    parameter int       PER_W       = 32,
    parameter int       SYNC_STAGES = 2,
    parameter pm_mode_e MODE        = PM_SUBTRACT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    output logic             edge_stb,
    output logic [TS_W-1:0]  stamp_q,
    output logic [PER_W-1:0] period_q,
    output logic             period_ok
);

    logic            pulse_s;
    logic            pulse_rise;
    logic [TS_W-1:0] tick;

    pm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pulse_in),
        .q_sync  (pulse_s)
    );

    pm_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (pulse_s),
        .rise  (pulse_rise)
    );

    pm_ticker #(.TS_W(TS_W)) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pm_period_unit #(.TS_W(TS_W), .PER_W(PER_W), .MODE(MODE)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (pulse_rise),
        .tick   (tick),
        .strobe (edge_stb),
        .stamp  (stamp_q),
        .period (period_q),
        .valid  (period_ok)
    );

endmodule

// File: rtl/pm_checker.sv
// Assertion checker for pulse_period_meter, attached with bind.
// Assumes PER_W < TS_W.
module pm_checker #(
    parameter int TS_W  = 64,
    parameter int PER_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edge_stb,
    input logic [TS_W-1:0]  stamp_q,
    input logic [PER_W-1:0] period_q,
    input logic             period_ok
);

    logic             rst_d;
    logic [TS_W-1:0]  stamp_d;
    logic [PER_W-1:0] period_d;
    logic [TS_W-1:0]  gap;
    logic             gap_over;

    // Keep last cycle's reset and output values for comparison.
    always_ff @(posedge clk) begin
        rst_d    <= rst_n;
        stamp_d  <= stamp_q;
        period_d <= period_q;
    end

    // Distance between the new and the previous timestamp.
    always_comb begin
        gap      = stamp_q - stamp_d;
        gap_over = |gap[TS_W-1:PER_W];
    end

    // R7: the strobe never lasts two cycles.
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |=> !edge_stb);

    // R7: without a strobe, timestamp and period hold their values.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_d && !edge_stb) |-> (stamp_q == stamp_d && period_q == period_d));

    // R5: the period equals the timestamp difference when it fits.
    p_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_d && edge_stb && period_ok && !gap_over) |-> (period_q == gap[PER_W-1:0]));

    // R6: an oversized difference gives all-ones.
    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_d && edge_stb && period_ok && gap_over) |-> (period_q == {PER_W{1'b1}}));

    // R8: valid rises only with a strobe and never drops outside reset.
    p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_d && $rose(period_ok)) |-> edge_stb);

    p_valid_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_d |-> !$fell(period_ok));

    // R4: no edge in the first cycle after reset release.
    p_startup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_d |=> !edge_stb);

endmodule

bind pulse_period_meter pm_checker #(.TS_W(TS_W), .PER_W(PER_W)) u_pm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_stb  (edge_stb),
    .stamp_q   (stamp_q),
    .period_q  (period_q),
    .period_ok (period_ok)
);

// File: tb/pulse_period_meter_test.sv
// Directed bench: one task per scenario, each checking its own results.
// Three copies of the block share one pulse line: the default copy, and
// subtract and count copies with an 8-bit period for saturation.
module pulse_period_meter_test;
    import pm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse = 1'b0;

    logic        stb;
    logic [63:0] stamp;
    logic [31:0] per;
    logic        ok;
    logic        stb_s8, stb_c8, ok_s8, ok_c8;
    logic [63:0] stamp_s8, stamp_c8;
    logic [7:0]  per_s8, per_c8;

    int          checks = 0;
    int          fails = 0;
    longint      bcnt = 0;
    int          stb_cnt = 0;
    int          edges = 0;
    longint      last_n = 0;

    always #5 clk = ~clk;

    pulse_period_meter uut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse), .edge_stb(stb),
        .stamp_q(stamp), .period_q(per), .period_ok(ok));

    pulse_period_meter #(.PER_W(8), .MODE(PM_SUBTRACT)) uut_s8 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse), .edge_stb(stb_s8),
        .stamp_q(stamp_s8), .period_q(per_s8), .period_ok(ok_s8));

    pulse_period_meter #(.PER_W(8), .MODE(PM_COUNT)) uut_c8 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse), .edge_stb(stb_c8),
        .stamp_q(stamp_c8), .period_q(per_c8), .period_ok(ok_c8));

    // Bench time base: clocks since reset release; strobe count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt    <= 0;
            stb_cnt <= 0;
        end else begin
            bcnt <= bcnt + 1;
            if (stb) stb_cnt <= stb_cnt + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset for a few cycles with the pulse at the given level.
    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst_n = 1'b0;
        pulse = lvl;
        repeat (3) @(negedge clk);
        chk("R9 stamp", stamp, 0);
        chk("R9 period", per, 0);
        chk("R9 ok", ok, 0);
        chk("R9 strobe", stb, 0);
        rst_n = 1'b1;
        edges = 0;
    endtask

    // Raise the pulse and check latency, timestamp, period and valid.
    task automatic rise();
        longint n;
        longint d;
        longint d8;
        @(negedge clk);
        n = bcnt;
        pulse = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 no strobe yet", stb, 0);
        @(negedge clk);
        chk("R2 R7 strobe", stb, 1);
        chk("R1 stamp", stamp, n + 2);
        if (edges >= 1) begin
            d  = n - last_n;
            d8 = (d > 255) ? 255 : d;
            chk("R5 period", per, d);
            chk("R8 ok", ok, 1);
            chk("R6 sub8 period", per_s8, d8);
            chk("R10 cnt8 period", per_c8, d8);
        end else begin
            chk("R8 ok after first", ok, 0);
        end
        @(negedge clk);
        chk("R7 strobe one cycle", stb, 0);
        last_n = n;
        edges++;
    endtask

    // Drop the pulse and wait; nothing may change (R3).
    task automatic fall(input int low_cycles);
        longint s;
        longint p;
        int     c;
        logic   v;
        s = stamp;
        p = per;
        v = ok;
        c = stb_cnt;
        @(negedge clk);
        pulse = 1'b0;
        repeat (low_cycles) @(negedge clk);
        chk("R3 no strobe on fall", stb_cnt, c);
        chk("R3 stamp held", stamp, s);
        chk("R3 period held", per, p);
        chk("R3 ok held", ok, v);
    endtask

    // Hold the input high through reset release: no edge (R4).
    task automatic t_startup();
        do_reset(1'b1);
        repeat (12) @(negedge clk);
        chk("R4 no startup strobe", stb_cnt, 0);
        chk("R4 stamp still zero", stamp, 0);
        fall(5);
        rise();
        chk("R4 one strobe after real edge", stb_cnt, 1);
    endtask

    // Several periods, including the shortest possible pattern.
    task automatic t_periods();
        repeat (20) @(negedge clk);
        fall(10);
        rise();
        repeat (30) @(negedge clk);
        fall(60);
        rise();
        fall(2);
        rise();
        fall(3);
        rise();
    endtask

    // Gaps over and near the 8-bit limit for saturation (R6, R10).
    task automatic t_saturate();
        fall(300);
        rise();
        fall(250);
        rise();
        fall(256);
        rise();
    endtask

    // Reset in the middle of a run clears everything (R9, R8).
    task automatic t_mid_reset();
        do_reset(1'b0);
        repeat (7) @(negedge clk);
        rise();
        fall(20);
        rise();
    endtask

    initial begin
        do_reset(1'b0);
        repeat (5) @(negedge clk);
        chk("R9 idle strobe", stb_cnt, 0);
        rise();
        fall(15);
        rise();
        t_periods();
        t_saturate();
        t_mid_reset();
        t_startup();
        fall(4);
        rise();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule